// File: doc/BRIEF.md
# Bitstream Front End with Start-Code Search

This block is the bit-level input stage of a variable length decoder for MPEG-1/2 video. It takes 32-bit words from a valid/ready stream (standing in for a DMA feeder), keeps them in a 64-bit bit buffer, and shows the next 16 bits of the stream as a look-ahead window. The window is read as a 32-bit value whose upper half is zero. A 32-bit counter totals every bit that has been consumed and wraps modulo 2^32.

Software drives the block through a command word made of a 4-bit opcode and an 8-bit argument. Opcode 0 clears the bit counter. Opcode 1 discards 0 to 15 bits. Opcode 2 hunts through the stream one bit per clock for a start code, which is the 24-bit prefix 0x000001 followed by the 8-bit code given in the argument. Every other opcode completes at once and has no effect. When a command completes, a done flag is set. An interrupt is raised on completion only if interrupts are enabled, and it stays high until a clear pulse is given. If input runs out partway through a command, the command waits for more data and does not report done.

Top module: `vbs_frontend`

## Requirements
- R1: After reset, cmd_ready is 1, done_o is 0, irq_o is 0 and bit_count_o is 0.
- R2: Opcode 1 discards exactly cmd_count[3:0] bits and ignores cmd_count[7:4]. Afterwards, window_o[15:0] holds the next 16 stream bits, with the oldest of them in bit 15.
- R3: window_o[31:16] always reads zero.
- R4: bit_count_o rises by the number of bits consumed. Opcode 0 sets it to zero and leaves the window unchanged.
- R5: Opcode 2 consumes bits up to and including the first start code whose code byte equals cmd_count[7:0]. That start code is 0x000001 followed by the byte, with the first bit received highest. Start codes with a different code byte are stepped over.
- R6: A command that lacks input data stalls with done_o at 0. Data supplied later lets it finish normally.
- R7: Accepting a command clears done_o. done_o is set when the command completes. Opcodes 0 and 3 to 15 complete in the first cycle after acceptance, and opcodes 3 to 15 change neither the counter nor the window. A shift completes one cycle after acceptance when enough data is buffered.
- R8: On completion, irq_o is set only if irq_en is 1. A one-cycle irq_clear pulse drops irq_o.
- R9: cmd_ready is 1 only while no command is running. A cmd_valid given while cmd_ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 32 | Stream word; the first bit is bit 31 |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | The buffer can take a word this cycle |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Opcode |
| cmd_count | input | 8 | Argument: shift amount or start-code byte |
| cmd_ready | output | 1 | Idle; a command can be accepted |
| irq_en | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Clear pulse for irq_o |
| done_o | output | 1 | Command done status |
| irq_o | output | 1 | Interrupt |
| window_o | output | 32 | Look-ahead window; the upper 16 bits are zero |
| bit_count_o | output | 32 | Wrapping count of consumed bits |

## Verification
The bench drives at the falling edge and samples at the next falling edge, so each command has a known sampling cycle. For opcode 0 and the unknown opcodes, done_o, the cleared counter and the interrupt are checked one falling edge after the strobe. For a shift, done_o is checked at 0 one falling edge after the strobe and at 1 at the following falling edge. A search lasts a data-dependent number of cycles, so the bench polls done_o with a bound. The window is checked three cycles after completion, once the buffer has refilled. Expected positions come from a bit-accurate scan of the bench's own copy of the stream.

// File: rtl/vbs_pkg.sv
// Shared definitions for the bitstream front end: opcodes, controller
// states and the start-code prefix. Assumes 32-bit stream words.
package vbs_pkg;
    localparam logic [3:0]  OP_INIT   = 4'd0;
    localparam logic [3:0]  OP_SHIFT  = 4'd1;
    localparam logic [3:0]  OP_SEARCH = 4'd2;
    localparam logic [23:0] SC_PREFIX = 24'h000001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_SEARCH = 2'd2
    } vbs_state_e;
endpackage

// File: rtl/vbs_bitbuf.sv
// Bit buffer: holds up to two words, MSB-aligned (bit BUF_W-1 is next).
// Each cycle it drops `consume` bits and, if room existed at the start of
// the cycle (fill <= WORD_W), appends one input word behind the rest.
// Assumes the consumer never asks for more bits than fill.
module vbs_bitbuf #(
    parameter int WORD_W = 32,
    parameter int BUF_W  = 2 * WORD_W,
    parameter int FILL_W = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FILL_W-1:0] consume,
    output logic [WORD_W-1:0] head,
    output logic [FILL_W-1:0] fill
);
    logic [BUF_W-1:0]  buf_q, buf_d, kept, placed;
    logic [FILL_W-1:0] fill_q, fill_d, fill_after;
    logic              load;

    // Room for a whole word decides the input handshake.
    assign in_ready = (fill_q <= FILL_W'(WORD_W));
    assign head     = buf_q[BUF_W-1 -: WORD_W];
    assign fill     = fill_q;

    // Next buffer contents: shift out consumed bits, append a word if taken.
    always_comb begin
        load       = in_valid && in_ready;
        fill_after = fill_q - consume;
        kept       = buf_q << consume;
        placed     = {in_data, {(BUF_W - WORD_W){1'b0}}} >> fill_after;
        buf_d      = load ? (kept | placed) : kept;
        fill_d     = fill_after + (load ? FILL_W'(WORD_W) : '0);
    end

    // Buffer and fill level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            fill_q <= '0;
        end else begin
            buf_q  <= buf_d;
            fill_q <= fill_d;
        end
    end

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(BUF_W));
    assert_consume_le_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        consume <= fill_q);
endmodule

// File: rtl/vbs_ctrl.sv
// Command controller: accepts a command only when idle, runs shift and
// start-code search, and reports completion. A search tests the buffer
// head once per clock, needing a full word buffered; on a miss it drops
// one bit, on a hit it drops the whole start code.
module vbs_ctrl
    import vbs_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int FILL_W  = 7,
    parameter int SHIFT_W = 4,
    parameter int CODE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [CODE_W-1:0] cmd_count,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] head,
    input  logic [FILL_W-1:0] fill,
    output logic [FILL_W-1:0] consume,
    output logic              clr_count,
    output logic              finish,
    output logic              done_o
);
    vbs_state_e          state_q;
    logic [SHIFT_W-1:0]  amount_q;
    logic [CODE_W-1:0]   code_q;
    logic                accept, run_done, instant;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign instant   = (cmd_code != OP_SHIFT) && (cmd_code != OP_SEARCH);
    assign clr_count = accept && (cmd_code == OP_INIT);
    assign finish    = run_done || (accept && instant);

    // Per-state consumption and completion for the running command.
    always_comb begin
        consume  = '0;
        run_done = 1'b0;
        case (state_q)
            ST_SHIFT: begin
                if (fill >= FILL_W'(amount_q)) begin
                    consume  = FILL_W'(amount_q);
                    run_done = 1'b1;
                end
            end
            ST_SEARCH: begin
                if (fill >= FILL_W'(WORD_W)) begin
                    if (head == {SC_PREFIX, code_q}) begin
                        consume  = FILL_W'(WORD_W);
                        run_done = 1'b1;
                    end else begin
                        consume = FILL_W'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    // State, latched arguments and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            amount_q <= '0;
            code_q   <= '0;
            done_o   <= 1'b0;
        end else if (accept) begin
            amount_q <= cmd_count[SHIFT_W-1:0];
            code_q   <= cmd_count;
            done_o   <= instant;
            case (cmd_code)
                OP_SHIFT:  state_q <= ST_SHIFT;
                OP_SEARCH: state_q <= ST_SEARCH;
                default:   state_q <= ST_IDLE;
            endcase
        end else if (run_done) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
        end
    end

    assert_done_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cmd_valid) || $past(state_q != ST_IDLE)));
    assert_busy_blocks_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !run_done) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/vbs_bitcount.sv
// Consumed-bit counter: adds the bits dropped each cycle, clears on the
// initialise command, and wraps modulo 2^CNT_W.
module vbs_bitcount #(
    parameter int CNT_W  = 32,
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [FILL_W-1:0] add,
    output logic [CNT_W-1:0]  count
);
    // Wrapping accumulation of consumed bits.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + CNT_W'(add);
    end

    assert_clr_no_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (add == '0));
endmodule

// File: rtl/vbs_frontend.sv
// Top of the bitstream front end: bit buffer, command controller, bit
// counter and interrupt flag. The window is the next WIN_W bits of the
// buffer, zero-extended to the register width.
module vbs_frontend #(
    parameter int WORD_W = 32,
    parameter int WIN_W  = 16,
    parameter int CNT_W  = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [CODE_W-1:0] cmd_count,
    output logic              cmd_ready,
    input  logic              irq_en,
    input  logic              irq_clear,
    output logic              done_o,
    output logic              irq_o,
    output logic [WORD_W-1:0] window_o,
    output logic [CNT_W-1:0]  bit_count_o
);
    localparam int BUF_W   = 2 * WORD_W;
    localparam int FILL_W  = $clog2(BUF_W + 1);
    localparam int SHIFT_W = 4;

    logic [WORD_W-1:0] head;
    logic [FILL_W-1:0] fill, consume;
    logic              clr_count, finish;

    vbs_bitbuf #(.WORD_W(WORD_W), .BUF_W(BUF_W), .FILL_W(FILL_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .consume(consume), .head(head), .fill(fill));

    vbs_ctrl #(.WORD_W(WORD_W), .FILL_W(FILL_W), .SHIFT_W(SHIFT_W), .CODE_W(CODE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_count(cmd_count), .cmd_ready(cmd_ready), .head(head), .fill(fill),
        .consume(consume), .clr_count(clr_count), .finish(finish), .done_o(done_o));

    vbs_bitcount #(.CNT_W(CNT_W), .FILL_W(FILL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_count), .add(consume), .count(bit_count_o));

    assign window_o = {{(WORD_W - WIN_W){1'b0}}, head[WORD_W-1 -: WIN_W]};

    // Interrupt flag: set on an enabled completion, dropped by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq_o <= 1'b0;
        else if (finish && irq_en)  irq_o <= 1'b1;
        else if (irq_clear)         irq_o <= 1'b0;
    end

    assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(irq_en));
    assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> done_o);
endmodule

// File: tb/test_vbs_frontend.sv
// Self-checking bench: a fixed bit stream with two start codes at
// unaligned positions. Expected positions come from a bit scan.
module test_vbs_frontend;
    localparam int NW = 24;
    localparam int NB = NW * 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] in_data;
    logic        in_valid, in_ready;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [7:0]  cmd_count;
    logic        cmd_ready, irq_en, irq_clear, done_o, irq_o;
    logic [31:0] window_o, bit_count_o;

    logic [31:0] stream [0:NW-1];
    int widx, feed_limit, pos, checks, fails;

    always #10 clk = ~clk;

    vbs_frontend i_vbs_frontend (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_count(cmd_count), .cmd_ready(cmd_ready), .irq_en(irq_en),
        .irq_clear(irq_clear), .done_o(done_o), .irq_o(irq_o),
        .window_o(window_o), .bit_count_o(bit_count_o));

    function automatic logic getbit(int p);
        return stream[p / 32][31 - (p % 32)];
    endfunction

    function automatic logic [31:0] win_at(int p);
        logic [31:0] w = '0;
        for (int i = 0; i < 16; i++) w[15 - i] = getbit(p + i);
        return w;
    endfunction

    // Position just past the first matching start code at or after p.
    function automatic int scan(int p, logic [7:0] code);
        for (int q = p; q + 32 <= NB; q++) begin
            logic [31:0] v = '0;
            for (int i = 0; i < 32; i++) v[31 - i] = getbit(q + i);
            if (v == {24'h000001, code}) return q + 32;
        end
        return -1;
    endfunction

    task automatic put32(int p, logic [31:0] v);
        for (int i = 0; i < 32; i++) stream[(p + i) / 32][31 - ((p + i) % 32)] = v[31 - i];
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Feeder: drive at the falling edge, note the handshake just before rising.
    initial begin
        in_valid = 1'b0;
        in_data  = '0;
        widx     = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) widx = 0;
            in_valid = rst_n && (widx < feed_limit);
            in_data  = stream[widx < NW ? widx : 0];
            #9;
            if (in_valid && in_ready) begin
                @(posedge clk);
                widx++;
            end
        end
    end

    // Strobe one command; returns at the first falling edge after acceptance.
    task automatic issue(logic [3:0] code, logic [7:0] arg);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_count = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(int limit);
        int n = 0;
        while (!done_o && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_clear();
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00C;
        checks = 0; fails = 0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; cmd_count = '0;
        irq_en = 1'b0; irq_clear = 1'b0; feed_limit = NW;
        for (int i = 0; i < NW; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} | 32'h0100_1010;
            stream[i] = lf;
        end
        put32(150, 32'h0000_01B5);
        put32(300, 32'h0000_01B3);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd_ready", {31'b0, cmd_ready}, 32'd1);
        chk("R1 done", {31'b0, done_o}, 32'd0);
        chk("R1 irq", {31'b0, irq_o}, 32'd0);
        chk("R1 count", bit_count_o, 32'd0);
        repeat (3) @(negedge clk);
        chk("R2 initial window", window_o, win_at(0));

        // R2/R7/R8 sweep of every shift amount with interrupts on.
        irq_en = 1'b1;
        pos = 0;
        for (int n = 0; n < 16; n++) begin
            issue(4'd1, 8'(n));
            chk("R7 done cleared on accept", {31'b0, done_o}, 32'd0);
            @(negedge clk);
            chk("R7 shift done one cycle later", {31'b0, done_o}, 32'd1);
            pos += n;
            repeat (3) @(negedge clk);
            chk("R4 count after shift", bit_count_o, 32'(pos));
            chk("R2 window after shift", window_o, win_at(pos));
            chk("R3 upper window zero", {16'b0, window_o[31:16]}, 32'd0);
            chk("R8 irq set", {31'b0, irq_o}, 32'd1);
            pulse_clear();
            chk("R8 irq cleared", {31'b0, irq_o}, 32'd0);
        end

        // R2: upper nibble of the argument is ignored.
        issue(4'd1, 8'hA5);
        wait_done(10);
        pos += 5;
        repeat (3) @(negedge clk);
        chk("R2 upper nibble ignored count", bit_count_o, 32'(pos));
        chk("R2 upper nibble ignored window", window_o, win_at(pos));
        pulse_clear();

        // R5: search for the first code, then for the second past it.
        issue(4'd2, 8'hB5);
        wait_done(2000);
        pos = scan(pos, 8'hB5);
        repeat (3) @(negedge clk);
        chk("R5 search B5 count", bit_count_o, 32'(pos));
        chk("R5 search B5 window", window_o, win_at(pos));
        issue(4'd2, 8'hB3);
        wait_done(2000);
        pos = scan(pos, 8'hB3);
        repeat (3) @(negedge clk);
        chk("R5 search B3 count", bit_count_o, 32'(pos));
        chk("R5 search B3 window", window_o, win_at(pos));
        chk("R8 irq after search", {31'b0, irq_o}, 32'd1);
        pulse_clear();

        // R4: initialise clears the counter; the window stays put.
        issue(4'd0, 8'h00);
        chk("R7 init done at once", {31'b0, done_o}, 32'd1);
        chk("R4 init clears count", bit_count_o, 32'd0);
        chk("R4 init keeps window", window_o, win_at(pos));
        pulse_clear();

        // R7/R8: unknown opcode with interrupts off.
        irq_en = 1'b0;
        issue(4'd7, 8'h0F);
        chk("R7 unknown done at once", {31'b0, done_o}, 32'd1);
        repeat (2) @(negedge clk);
        chk("R7 unknown keeps count", bit_count_o, 32'd0);
        chk("R7 unknown keeps window", window_o, win_at(pos));
        chk("R8 no irq when disabled", {31'b0, irq_o}, 32'd0);

        // R6/R9: starve the input during a search from the stream start.
        rst_n = 1'b0;
        feed_limit = 4;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b1;
        repeat (2) @(negedge clk);
        issue(4'd2, 8'hB3);
        repeat (300) @(negedge clk);
        chk("R6 stalled not done", {31'b0, done_o}, 32'd0);
        chk("R6 stalled count", bit_count_o, 32'(4 * 32 - 31));
        chk("R9 busy not ready", {31'b0, cmd_ready}, 32'd0);
        cmd_valid = 1'b1; cmd_code = 4'd0; cmd_count = 8'h00;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R9 init ignored while busy", bit_count_o, 32'(4 * 32 - 31));
        feed_limit = NW;
        wait_done(2000);
        pos = scan(0, 8'hB3);
        repeat (3) @(negedge clk);
        chk("R6 resumed done", {31'b0, done_o}, 32'd1);
        chk("R6 resumed count", bit_count_o, 32'(pos));
        chk("R5 skipped B5 window", window_o, win_at(pos));
        chk("R8 irq after resume", {31'b0, irq_o}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule